// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block drives a register-mapped sigma-delta converter through a simple register-access master port. One request runs a single conversion. The block programs the input multiplexer, then the reference and polarity controls, then the gain path. It waits an optional per-channel settling time, writes the start command and waits for the converter to report a result. It then fetches the 24-bit sample. The result can be awaited in two ways: on a rising edge of a ready interrupt, or by reading a ready flag in the status register at a paced interval. A timeout limit applies in both cases.

A second request runs the converter freely. The block configures the channel in the same way and starts continuous conversion. Each rising edge of the interrupt then causes one result fetch, until a stop request ends continuous mode. Every register access takes one transaction on the master port. The number of bytes moved by a transaction depends on the register address. Errors end the sequence and are reported with a code when the block returns to idle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and after reset the block is idle: `busy`, `done`, `res_valid` and `rp_req` are low, and `rp_req` stays low whenever the block is idle.
- R2: Every transaction states its length on `rp_len`: 1 byte for addresses 0x00 to 0x10, and 3 bytes for every higher address.
- R3: The result register (0x30) is read as 3 bytes, most significant byte first. They are assembled into `res_data`, which is presented with a one-cycle `res_valid`.
- R4: The multiplexer register (0x0B) is written with the positive input index in bits 7:4 and the negative index in bits 3:0. When `cfg_diff` is low, the negative index is 10, which selects ground.
- R5: If the positive index, or the negative index of a differential channel, is above 10, the request ends at once with `err_code` 1 and `done`, and no register is accessed.
- R6: The control register (0x09) is read and then written back. Reference select goes in bits 2:0, the negative-reference buffer in bit 3, the positive-reference buffer in bit 4, and unipolar (the inverse of `cfg_bipolar`) in bit 6. Bits 5 and 7 keep the values that were read.
- R7: The gain register (0x0E) is written whole, with the signal path in bits 5:4 and the gain code in bits 2:0. All other bits are zero.
- R8: A single conversion issues, in order: write 0x0B, read 0x09, write 0x09, write 0x0E, write 0x00 to 0x01, then read 0x30. It then pulses `done` with `err_code` 0. Each transaction holds its request and fields until `rp_done`.
- R9: When `cfg_settle_us` is nonzero, at least that many microseconds of clock cycles pass between the gain write and the start write.
- R10: With `use_irq` low, the block waits one poll interval and then reads status register 0x38. It repeats this until bit 0 is set, so successive status reads are at least one poll interval apart. The result is then read.
- R11: If no result is ready within the timeout interval after the start write, the request ends with `err_code` 2. This applies with the interrupt and with polling.
- R12: A transaction that ends with `rp_err` aborts the sequence. The block returns to idle with `err_code` 3 and makes no further access.
- R13: A continuous request configures the channel and writes 0x01 to register 0x01. Each rising edge of `irq_in` then gives one read of 0x30 and one `res_valid`. `req_stop` writes 0x00 to register 0x01 and ends with `done` and `err_code` 0.
- R14: `req_single` and `req_cont` are ignored unless the block is idle, and `req_stop` is ignored unless continuous mode is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_single | input | 1 | Start one conversion (sampled in idle) |
| req_cont | input | 1 | Start continuous conversion (sampled in idle) |
| req_stop | input | 1 | Stop continuous conversion |
| use_irq | input | 1 | 1: wait on interrupt, 0: poll the status flag |
| cfg_pos | input | 4 | Positive input index |
| cfg_neg | input | 4 | Negative input index (differential only) |
| cfg_diff | input | 1 | Channel is differential |
| cfg_ref | input | 3 | Reference select code |
| cfg_bufp | input | 1 | Buffer the positive reference |
| cfg_bufn | input | 1 | Buffer the negative reference |
| cfg_bipolar | input | 1 | Bipolar input range |
| cfg_path | input | 2 | Signal path: 0 buffered, 1 bypass, 2 amplifier |
| cfg_gain | input | 3 | Gain code |
| cfg_settle_us | input | SET_W | Settling time in microseconds |
| irq_in | input | 1 | Asynchronous ready interrupt from the converter |
| rp_req | output | 1 | Transaction request, held until `rp_done` |
| rp_we | output | 1 | Transaction is a write |
| rp_addr | output | 8 | Register address |
| rp_wdata | output | 8 | Write byte |
| rp_len | output | 2 | Bytes in the transaction (1 or 3) |
| rp_rvalid | input | 1 | A read byte is on `rp_rbyte` |
| rp_rbyte | input | 8 | Read byte, most significant first |
| rp_done | input | 1 | Transaction finished |
| rp_err | input | 1 | Transaction failed (valid with `rp_done`) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence strobe |
| err_code | output | 2 | 0 ok, 1 bad index, 2 timeout, 3 port error |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Conversion result |

## Verification
The conditions that are hardest to reach from the ports are the aborts in the middle of a sequence. These are a port error on the read half of the control update and the two timeout paths. A scripted register responder counts every transaction, so the bench can fail a chosen transaction by its index. For the timeouts, the responder withholds the ready flag indefinitely, or the interrupt is never raised. In each case the bench measures elapsed cycles from the start write to `done` against the configured limit. The bench then confirms that no access follows the abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [7:0] A_START   = 8'h01;
  localparam logic [7:0] A_CTRL    = 8'h09;
  localparam logic [7:0] A_MUX     = 8'h0B;
  localparam logic [7:0] A_GAIN    = 8'h0E;
  localparam logic [7:0] A_DATA    = 8'h30;
  localparam logic [7:0] A_STAT    = 8'h38;
  localparam logic [7:0] A_NARROW  = 8'h10;  // last one-byte address
  localparam logic [3:0] IDX_LIMIT = 4'd10;  // also the ground selection
  localparam logic [7:0] CTL_KEEP  = 8'hA0;  // bits kept on control update

  typedef enum logic [1:0] {
    E_OK      = 2'd0,
    E_RANGE   = 2'd1,
    E_TIMEOUT = 2'd2,
    E_PORT    = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_MUX, S_CTLR, S_CTLW, S_GAIN, S_SETTLE, S_START,
    S_WIRQ, S_PGAP, S_PRD, S_DATA, S_CONT, S_STOP
  } st_e;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
  } cmd_t;

  function automatic cmd_t mk_cmd(logic we, logic [7:0] a, logic [7:0] d);
    return cmd_t'({we, a, d});
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sync;

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[STAGES-1:0], din};
  end

  assign rise = sync[STAGES-1] & ~sync[STAGES];
endmodule

// File: rtl/adc_seq_port.sv
module adc_seq_port
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  cmd_t             cmd,
  output logic             rp_req,
  output logic             rp_we,
  output logic [7:0]       rp_addr,
  output logic [7:0]       rp_wdata,
  output logic [1:0]       rp_len,
  input  logic             rp_rvalid,
  input  logic [7:0]       rp_rbyte,
  input  logic             rp_done,
  input  logic             rp_err,
  output logic             fin,
  output logic             fin_err,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_req   <= 1'b0;
      rp_we    <= 1'b0;
      rp_addr  <= '0;
      rp_wdata <= '0;
      rp_len   <= 2'd1;
      fin      <= 1'b0;
      fin_err  <= 1'b0;
      rdata    <= '0;
      acc      <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !rp_req) begin
        rp_req   <= 1'b1;
        rp_we    <= cmd.we;
        rp_addr  <= cmd.addr;
        rp_wdata <= cmd.data;
        rp_len   <= (cmd.addr > A_NARROW) ? 2'd3 : 2'd1;
        acc      <= '0;
      end else if (rp_req) begin
        if (rp_rvalid) acc <= {acc[RES_W-9:0], rp_rbyte};
        if (rp_done) begin
          rp_req  <= 1'b0;
          fin     <= 1'b1;
          fin_err <= rp_err;
          rdata   <= acc;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int POLL_US    = 5_000,
  parameter int TIMEOUT_US = 2_000_000,
  parameter int SET_W      = 16,
  parameter int RES_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_single,
  input  logic             req_cont,
  input  logic             req_stop,
  input  logic             use_irq,
  input  logic [3:0]       cfg_pos,
  input  logic [3:0]       cfg_neg,
  input  logic             cfg_diff,
  input  logic [2:0]       cfg_ref,
  input  logic             cfg_bufp,
  input  logic             cfg_bufn,
  input  logic             cfg_bipolar,
  input  logic [1:0]       cfg_path,
  input  logic [2:0]       cfg_gain,
  input  logic [SET_W-1:0] cfg_settle_us,
  input  logic             irq_in,
  output logic             rp_req,
  output logic             rp_we,
  output logic [7:0]       rp_addr,
  output logic [7:0]       rp_wdata,
  output logic [1:0]       rp_len,
  input  logic             rp_rvalid,
  input  logic [7:0]       rp_rbyte,
  input  logic             rp_done,
  input  logic             rp_err,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  localparam int US_CYC   = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int POLL_CYC = POLL_US * US_CYC;
  localparam int TMO_CYC  = TIMEOUT_US * US_CYC;
  localparam int SET_MAX  = ((1 << SET_W) - 1) * US_CYC;
  localparam int MAXC     = (TMO_CYC > SET_MAX) ? TMO_CYC : SET_MAX;
  localparam int TW       = $clog2(MAXC + 1);

  st_e  st;
  err_e err_q;
  cmd_t cmd;
  logic go, fin, fin_err;
  logic [RES_W-1:0] rdata;
  logic gap_ld, tmo_ld, gap_exp, tmo_exp, irq_rise;
  logic [TW-1:0] gap_val;
  logic irq_pend, stop_pend, mode_cont, wait_irq;

  // latched channel settings
  logic [3:0] pos_q, neg_q;
  logic [2:0] ref_q, gain_q;
  logic [1:0] path_q;
  logic       bufp_q, bufn_q, bip_q;
  logic [SET_W-1:0] settle_q;

  logic bad_idx;
  assign bad_idx = (cfg_pos > IDX_LIMIT) || (cfg_diff && (cfg_neg > IDX_LIMIT));

  adc_seq_port #(.RES_W(RES_W)) i_port (
    .clk(clk), .rst(rst), .go(go), .cmd(cmd),
    .rp_req(rp_req), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_len(rp_len), .rp_rvalid(rp_rvalid), .rp_rbyte(rp_rbyte),
    .rp_done(rp_done), .rp_err(rp_err),
    .fin(fin), .fin_err(fin_err), .rdata(rdata)
  );

  adc_seq_timer #(.W(TW)) i_gap (
    .clk(clk), .rst(rst), .load(gap_ld), .value(gap_val), .expired(gap_exp)
  );

  adc_seq_timer #(.W(TW)) i_tmo (
    .clk(clk), .rst(rst), .load(tmo_ld), .value(TW'(TMO_CYC)), .expired(tmo_exp)
  );

  adc_seq_edge #(.STAGES(2)) i_irq (
    .clk(clk), .rst(rst), .din(irq_in), .rise(irq_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      err_q     <= E_OK;
      cmd       <= '0;
      go        <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      gap_ld    <= 1'b0;
      gap_val   <= '0;
      tmo_ld    <= 1'b0;
      irq_pend  <= 1'b0;
      stop_pend <= 1'b0;
      mode_cont <= 1'b0;
      wait_irq  <= 1'b0;
      pos_q     <= '0;
      neg_q     <= '0;
      ref_q     <= '0;
      gain_q    <= '0;
      path_q    <= '0;
      bufp_q    <= 1'b0;
      bufn_q    <= 1'b0;
      bip_q     <= 1'b0;
      settle_q  <= '0;
    end else begin
      go        <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      gap_ld    <= 1'b0;
      tmo_ld    <= 1'b0;

      if (st != S_IDLE && fin && fin_err) begin
        st    <= S_IDLE;
        done  <= 1'b1;
        err_q <= E_PORT;
      end else begin
        case (st)
          S_IDLE: begin
            if (req_single || req_cont) begin
              stop_pend <= 1'b0;
              mode_cont <= !req_single;
              wait_irq  <= use_irq;
              pos_q     <= cfg_pos;
              neg_q     <= cfg_diff ? cfg_neg : IDX_LIMIT;
              ref_q     <= cfg_ref;
              gain_q    <= cfg_gain;
              path_q    <= cfg_path;
              bufp_q    <= cfg_bufp;
              bufn_q    <= cfg_bufn;
              bip_q     <= cfg_bipolar;
              settle_q  <= cfg_settle_us;
              if (bad_idx) begin
                done  <= 1'b1;
                err_q <= E_RANGE;
              end else begin
                err_q <= E_OK;
                st    <= S_MUX;
                go    <= 1'b1;
                cmd   <= mk_cmd(1'b1, A_MUX,
                                {cfg_pos, cfg_diff ? cfg_neg : IDX_LIMIT});
              end
            end
          end
          S_MUX: if (fin) begin
            st  <= S_CTLR;
            go  <= 1'b1;
            cmd <= mk_cmd(1'b0, A_CTRL, 8'h00);
          end
          S_CTLR: if (fin) begin
            st  <= S_CTLW;
            go  <= 1'b1;
            cmd <= mk_cmd(1'b1, A_CTRL, (rdata[7:0] & CTL_KEEP) |
                          {1'b0, ~bip_q, 1'b0, bufp_q, bufn_q, ref_q});
          end
          S_CTLW: if (fin) begin
            st  <= S_GAIN;
            go  <= 1'b1;
            cmd <= mk_cmd(1'b1, A_GAIN, {2'b00, path_q, 1'b0, gain_q});
          end
          S_GAIN: if (fin) begin
            if (settle_q != '0) begin
              st      <= S_SETTLE;
              gap_ld  <= 1'b1;
              gap_val <= TW'(settle_q) * TW'(US_CYC);
            end else begin
              st       <= S_START;
              go       <= 1'b1;
              irq_pend <= 1'b0;
              cmd      <= mk_cmd(1'b1, A_START, {7'd0, mode_cont});
            end
          end
          S_SETTLE: if (!gap_ld && gap_exp) begin
            st       <= S_START;
            go       <= 1'b1;
            irq_pend <= 1'b0;
            cmd      <= mk_cmd(1'b1, A_START, {7'd0, mode_cont});
          end
          S_START: if (fin) begin
            if (mode_cont) begin
              st <= S_CONT;
            end else begin
              tmo_ld <= 1'b1;
              if (wait_irq) begin
                st <= S_WIRQ;
              end else begin
                st      <= S_PGAP;
                gap_ld  <= 1'b1;
                gap_val <= TW'(POLL_CYC);
              end
            end
          end
          S_WIRQ: begin
            if (irq_pend) begin
              st       <= S_DATA;
              go       <= 1'b1;
              irq_pend <= 1'b0;
              cmd      <= mk_cmd(1'b0, A_DATA, 8'h00);
            end else if (!tmo_ld && tmo_exp) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              err_q <= E_TIMEOUT;
            end
          end
          S_PGAP: if (!gap_ld && gap_exp) begin
            if (tmo_exp) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              err_q <= E_TIMEOUT;
            end else begin
              st  <= S_PRD;
              go  <= 1'b1;
              cmd <= mk_cmd(1'b0, A_STAT, 8'h00);
            end
          end
          S_PRD: if (fin) begin
            if (rdata[0]) begin
              st  <= S_DATA;
              go  <= 1'b1;
              cmd <= mk_cmd(1'b0, A_DATA, 8'h00);
            end else if (tmo_exp) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              err_q <= E_TIMEOUT;
            end else begin
              st      <= S_PGAP;
              gap_ld  <= 1'b1;
              gap_val <= TW'(POLL_CYC);
            end
          end
          S_DATA: if (fin) begin
            res_data  <= rdata;
            res_valid <= 1'b1;
            if (mode_cont) begin
              st <= S_CONT;
            end else begin
              st    <= S_IDLE;
              done  <= 1'b1;
              err_q <= E_OK;
            end
          end
          S_CONT: begin
            if (stop_pend) begin
              st        <= S_STOP;
              stop_pend <= 1'b0;
              go        <= 1'b1;
              cmd       <= mk_cmd(1'b1, A_START, 8'h00);
            end else if (irq_pend) begin
              st       <= S_DATA;
              go       <= 1'b1;
              irq_pend <= 1'b0;
              cmd      <= mk_cmd(1'b0, A_DATA, 8'h00);
            end
          end
          S_STOP: if (fin) begin
            st    <= S_IDLE;
            done  <= 1'b1;
            err_q <= E_OK;
          end
          default: st <= S_IDLE;
        endcase
      end

      // late assignments win over the clears above
      if (irq_rise) irq_pend <= 1'b1;
      if (req_stop && mode_cont && (st == S_CONT || st == S_DATA))
        stop_pend <= 1'b1;
    end
  end

  assign busy     = (st != S_IDLE);
  assign err_code = err_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rp_req,
  input logic       rp_we,
  input logic [7:0] rp_addr,
  input logic [7:0] rp_wdata,
  input logic [1:0] rp_len,
  input logic       rp_done,
  input logic       rp_err,
  input logic       busy,
  input logic       done,
  input logic       res_valid
);
  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rp_req);

  assert_len_by_addr_R2: assert property (@(posedge clk) disable iff (rst)
    rp_req |-> rp_len == ((rp_addr > 8'h10) ? 2'd3 : 2'd1));

  assert_mux_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (rp_req && rp_we && rp_addr == 8'h0B) |->
      (rp_wdata[7:4] <= 4'd10 && rp_wdata[3:0] <= 4'd10));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (rp_req && !rp_done) |=>
      (rp_req && $stable(rp_addr) && $stable(rp_we) && $stable(rp_wdata)));

  assert_done_in_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_abort_on_err_R12: assert property (@(posedge clk) disable iff (rst)
    (rp_req && rp_done && rp_err) |=> ##1 !busy);

  assert_result_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk i_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int POLL = 20;
  localparam int TMO  = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic req_single = 0, req_cont = 0, req_stop = 0, use_irq = 1;
  logic [3:0] cfg_pos = 0, cfg_neg = 0;
  logic cfg_diff = 0, cfg_bufp = 0, cfg_bufn = 0, cfg_bipolar = 0;
  logic [2:0] cfg_ref = 0, cfg_gain = 0;
  logic [1:0] cfg_path = 0;
  logic [15:0] cfg_settle_us = 0;
  logic irq_in = 1'b0;
  logic rp_req, rp_we;
  logic [7:0] rp_addr, rp_wdata;
  logic [1:0] rp_len;
  logic rp_rvalid, rp_done, rp_err;
  logic [7:0] rp_rbyte;
  logic busy, done, res_valid;
  logic [1:0] err_code;
  logic [23:0] res_data;

  adc_seq_ctrl #(.CLK_HZ(1_000_000), .POLL_US(POLL), .TIMEOUT_US(TMO)) i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .req_single(req_single), .req_cont(req_cont),
    .req_stop(req_stop), .use_irq(use_irq), .cfg_pos(cfg_pos), .cfg_neg(cfg_neg),
    .cfg_diff(cfg_diff), .cfg_ref(cfg_ref), .cfg_bufp(cfg_bufp), .cfg_bufn(cfg_bufn),
    .cfg_bipolar(cfg_bipolar), .cfg_path(cfg_path), .cfg_gain(cfg_gain),
    .cfg_settle_us(cfg_settle_us), .irq_in(irq_in),
    .rp_req(rp_req), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_len(rp_len), .rp_rvalid(rp_rvalid), .rp_rbyte(rp_rbyte),
    .rp_done(rp_done), .rp_err(rp_err), .busy(busy), .done(done),
    .err_code(err_code), .res_valid(res_valid), .res_data(res_data)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // main-written controls for the responder
  logic [23:0] data_val = 24'h0;
  int stat_ready_at = 0, err_at = -1, man_req = 0;
  bit irq_auto = 1;

  // responder-written state
  logic       lg_we   [1024];
  logic [7:0] lg_addr [1024];
  logic [1:0] lg_len  [1024];
  logic [23:0] lg_data [1024];
  int         lg_t    [1024];
  int lg_n = 0, stat_reads = 0, start_evt = 0;
  logic [7:0] ctl_model = 8'hA0;

  initial begin
    rp_rvalid = 0; rp_rbyte = 0; rp_done = 0; rp_err = 0;
    forever begin
      @(negedge clk);
      if (rp_req && !rst) begin : serve
        int idx;
        logic [23:0] v;
        bit inj;
        idx = lg_n % 1024;
        inj = (lg_n == err_at);
        v = 24'h0;
        lg_we[idx] = rp_we; lg_addr[idx] = rp_addr; lg_len[idx] = rp_len; lg_t[idx] = cyc;
        if (rp_we) begin
          lg_data[idx] = {16'h0, rp_wdata};
          if (rp_addr == 8'h09) ctl_model = rp_wdata;
          if (rp_addr == 8'h01 && rp_wdata == 8'h00) start_evt++;
        end else begin
          case (rp_addr)
            8'h09: v = {16'h0, ctl_model};
            8'h38: begin v = (stat_reads >= stat_ready_at) ? 24'h1 : 24'h0; stat_reads++; end
            8'h30: v = data_val;
            default: v = 24'h0;
          endcase
          lg_data[idx] = v;
        end
        lg_n++;
        repeat (2) @(negedge clk);
        if (!rp_we) begin
          for (int b = 0; b < int'(rp_len); b++) begin
            rp_rvalid = 1;
            rp_rbyte = 8'(v >> (8 * (int'(rp_len) - 1 - b)));
            @(negedge clk);
            rp_rvalid = 0;
          end
        end
        rp_done = 1; rp_err = inj;
        @(negedge clk);
        rp_done = 0; rp_err = 0;
      end
    end
  end

  // interrupt source: after a single-start write (if auto) or on bench request
  int st_seen = 0, man_seen = 0, cd = 0;
  always @(negedge clk) begin
    if (start_evt != st_seen) begin
      st_seen = start_evt;
      if (irq_auto) cd = 7;
    end else if (man_req != man_seen) begin
      man_seen = man_req;
      cd = 7;
    end
    if (cd > 0) cd--;
    irq_in = (cd > 0 && cd <= 3);
  end

  int n_done = 0, done_t = 0, n_res = 0;
  logic [1:0] done_err = 0;
  logic [23:0] res_last = 0;
  always @(negedge clk) if (!rst) begin
    if (done) begin n_done++; done_err = err_code; done_t = cyc; end
    if (res_valid) begin n_res++; res_last = res_data; end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_done(int d0);
    for (int i = 0; i < 4000 && n_done == d0; i++) @(negedge clk);
  endtask

  task automatic fire_single();
    @(negedge clk); req_single = 1;
    @(negedge clk); req_single = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base, d0, r0;
    logic [23:0] exp_v;
    bit ok;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!busy && !rp_req && !done && !res_valid, "R1", "reset outputs",
        {busy, rp_req, done, res_valid}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !rp_req, "R1", "idle after reset", {busy, rp_req}, 0);

    // sweep over all input indices: R2 R3 R4 R6 R7 R8
    use_irq = 1; irq_auto = 1;
    for (int p = 0; p <= 10; p++) begin
      cfg_pos = 4'(p); cfg_neg = 4'((p + 3) % 11); cfg_diff = p[0];
      cfg_gain = 3'(p % 8); cfg_path = 2'(p % 3); cfg_ref = 3'(p % 7);
      cfg_bipolar = p[0] ^ p[1]; cfg_bufp = p[1]; cfg_bufn = p[2];
      data_val = 24'h800000 ^ (24'(p) * 24'h13579);
      base = lg_n; d0 = n_done; r0 = n_res;
      fire_single();
      wait_done(d0);
      chk(done_err == 0 && n_res == r0 + 1 && res_last == data_val, "R3",
          "result value", res_last, data_val);
      ok = (lg_n - base == 6) &&
           lg_we[base] && lg_addr[base] == 8'h0B &&
           !lg_we[base+1] && lg_addr[base+1] == 8'h09 &&
           lg_we[base+2] && lg_addr[base+2] == 8'h09 &&
           lg_we[base+3] && lg_addr[base+3] == 8'h0E &&
           lg_we[base+4] && lg_addr[base+4] == 8'h01 && lg_data[base+4] == 0 &&
           !lg_we[base+5] && lg_addr[base+5] == 8'h30;
      chk(ok, "R8", "access order", lg_n - base, 6);
      exp_v = {16'h0, 4'(p), cfg_diff ? cfg_neg : 4'd10};
      chk(lg_data[base] == exp_v, "R4", "mux byte", lg_data[base], exp_v);
      exp_v = {16'h0, 1'b1, ~cfg_bipolar, 1'b1, cfg_bufp, cfg_bufn, cfg_ref};
      chk(lg_data[base+2] == exp_v, "R6", "control byte", lg_data[base+2], exp_v);
      exp_v = {16'h0, 2'b00, cfg_path, 1'b0, cfg_gain};
      chk(lg_data[base+3] == exp_v, "R7", "gain byte", lg_data[base+3], exp_v);
      ok = 1;
      for (int k = 0; k < 6; k++)
        ok &= (lg_len[base+k] == ((lg_addr[base+k] > 8'h10) ? 2'd3 : 2'd1));
      chk(ok, "R2", "transaction lengths", lg_len[base+5], 3);
    end

    // R5: out-of-range indices
    cfg_diff = 0; cfg_pos = 4'd11;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(done_err == 1 && lg_n == base, "R5", "positive index 11", done_err, 1);
    cfg_diff = 1; cfg_pos = 4'd2; cfg_neg = 4'd12;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(done_err == 1 && lg_n == base, "R5", "negative index 12", done_err, 1);
    cfg_neg = 4'd10;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(done_err == 0 && lg_n - base == 6, "R5", "index 10 accepted", done_err, 0);

    // R9: settling delay
    cfg_settle_us = 16'd40;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(lg_t[base+4] - lg_t[base+3] >= 40 && lg_t[base+4] - lg_t[base+3] <= 60,
        "R9", "gain-to-start gap", lg_t[base+4] - lg_t[base+3], 40);
    cfg_settle_us = 0;

    // R10: polling, ready on third status read
    use_irq = 0; irq_auto = 0;
    stat_ready_at = stat_reads + 2;
    data_val = 24'h5A17C3;
    base = lg_n; d0 = n_done; r0 = n_res; fire_single(); wait_done(d0);
    ok = (lg_n - base == 9);
    for (int k = 5; k < 8; k++) ok &= (!lg_we[base+k] && lg_addr[base+k] == 8'h38);
    chk(ok, "R10", "three status reads then data", lg_n - base, 9);
    ok = (lg_t[base+5] - lg_t[base+4] >= POLL) && (lg_t[base+6] - lg_t[base+5] >= POLL) &&
         (lg_t[base+7] - lg_t[base+6] >= POLL);
    chk(ok, "R10", "poll spacing", lg_t[base+6] - lg_t[base+5], POLL);
    chk(done_err == 0 && res_last == data_val, "R10", "polled result", res_last, data_val);

    // R11: poll timeout
    stat_ready_at = 1 << 30;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(done_err == 2, "R11", "poll timeout code", done_err, 2);
    chk(done_t - lg_t[base+4] >= TMO && done_t - lg_t[base+4] <= TMO + 80, "R11",
        "poll timeout time", done_t - lg_t[base+4], TMO);

    // R11: interrupt timeout
    use_irq = 1;
    base = lg_n; d0 = n_done; fire_single(); wait_done(d0);
    chk(done_err == 2, "R11", "irq timeout code", done_err, 2);
    chk(done_t - lg_t[base+4] >= TMO && done_t - lg_t[base+4] <= TMO + 30, "R11",
        "irq timeout time", done_t - lg_t[base+4], TMO);

    // R12: port error on control read
    irq_auto = 1;
    base = lg_n; err_at = base + 1; d0 = n_done; fire_single(); wait_done(d0);
    repeat (20) @(negedge clk);
    chk(done_err == 3 && !busy, "R12", "port error code", done_err, 3);
    chk(lg_n - base == 2, "R12", "no access after error", lg_n - base, 2);
    err_at = -1;

    // R14: stop in idle ignored
    d0 = n_done; base = lg_n;
    @(negedge clk); req_stop = 1; @(negedge clk); req_stop = 0;
    repeat (10) @(negedge clk);
    chk(!busy && lg_n == base && n_done == d0, "R14", "stop in idle", lg_n - base, 0);

    // R13: continuous mode
    irq_auto = 0;
    base = lg_n; d0 = n_done;
    @(negedge clk); req_cont = 1; @(negedge clk); req_cont = 0;
    for (int i = 0; i < 300 && (lg_n - base) < 5; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(lg_n - base == 5 && lg_we[base+4] && lg_addr[base+4] == 8'h01 &&
        lg_data[base+4] == 24'h1 && busy, "R13", "continuous start", lg_data[base+4], 1);
    // R14: single request while running is ignored
    fire_single();
    @(negedge clk); req_cont = 1; @(negedge clk); req_cont = 0;
    repeat (30) @(negedge clk);
    chk(lg_n - base == 5 && n_done == d0, "R14", "request while busy", lg_n - base, 5);
    for (int k = 0; k < 3; k++) begin
      data_val = 24'h0F00F0 + 24'(k * 24'h111111);
      r0 = n_res;
      man_req++;
      for (int i = 0; i < 200 && n_res == r0; i++) @(negedge clk);
      chk(n_res == r0 + 1 && res_last == data_val && n_done == d0, "R13",
          "continuous result", res_last, data_val);
    end
    @(negedge clk); req_stop = 1; @(negedge clk); req_stop = 0;
    wait_done(d0);
    repeat (3) @(negedge clk);
    chk(done_err == 0 && !busy && lg_we[(lg_n-1)%1024] && lg_addr[(lg_n-1)%1024] == 8'h01 &&
        lg_data[(lg_n-1)%1024] == 0, "R13", "continuous stop", lg_data[(lg_n-1)%1024], 0);
    chk(lg_n - base == 9, "R13", "one read per edge", lg_n - base, 9);

    finish_run();
  end
endmodule